// File: doc/BRIEF.md
# Link Power State Controller

This block is the device-side state machine that tracks the operating and low-power states of a host-to-device communication link. It leaves reset once the device signals internal readiness. It waits for the host to request the operational state, and then moves between operational, idle, sleep and host-suspended states. Some of these moves come from host requests, some from physical-link activity, and some from two programmable inactivity timers.

The host's requested-state register is seen as a one-cycle write strobe with a 3-bit code. The controller publishes its current state code and two permission flags. One flag allows host register access, which is refused in the reset state. The other allows channels to run, which happens only in the operational state. Every state change produces a one-cycle event request for the event ring producer, and that request carries the new state code. A host write that arrives while the controller is in reset is dropped and reported on a one-cycle flag.

State codes: RESET=0, READY=1, ACTIVE=2, IDLE=3, SLEEP=4, SUSPEND=5.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `stateCode` is 0 (RESET), `regAccessOk`, `chanRunOk`, `evtValid` and `wrDropped` are 0.
- R2: In RESET, `devReady` high at a clock edge moves the state to READY (code 1) at that edge; without it the state stays RESET.
- R3: A `reqValid` strobe taken in RESET changes no state and sets `wrDropped` high for exactly the following cycle; `wrDropped` is low in every other case.
- R4: In READY only a request with code 2 has an effect, moving to ACTIVE; requests with any other code leave the state at READY.
- R5: `regAccessOk` is high in every state except RESET; `chanRunOk` is high only in ACTIVE.
- R6: In ACTIVE, after `idleLimitFast` consecutive sampled cycles with `linkActive` low, the state becomes IDLE (code 3) at the edge of the last such cycle. Any cycle with `linkActive` high restarts the count. A limit of 0 disables the timeout, and lowering the limit below the count already reached expires on the next idle cycle.
- R7: In IDLE, `linkActive` high moves the state back to ACTIVE at the next edge, and the ACTIVE timeout counts from zero again.
- R8: In IDLE, after `idleLimitSlow` consecutive idle cycles the state becomes SLEEP (code 4); a limit of 0 disables this step.
- R9: In SLEEP, `linkActive` high moves the state to ACTIVE at the next edge; no timer runs in SLEEP.
- R10: A request with code 5 taken in ACTIVE, IDLE or SLEEP moves the state to SUSPEND (code 5). It wins over link activity and timer expiry in the same cycle.
- R11: In SUSPEND only a request with code 2 has an effect, moving to ACTIVE; link activity and other requests leave the state at SUSPEND.
- R12: `evtValid` is high for exactly one cycle, the first cycle in which `stateCode` shows a new state, with `evtState` equal to that new code; `evtValid` is low whenever the state did not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | One-cycle strobe: host wrote the requested-state register |
| reqState | input | 3 | Requested state code written by the host |
| linkActive | input | 1 | Physical-link activity seen in this cycle |
| devReady | input | 1 | Internal ready indication from device bring-up |
| idleLimitFast | input | TIMER_W | Idle cycles in ACTIVE before moving to IDLE (0 = off) |
| idleLimitSlow | input | TIMER_W | Idle cycles in IDLE before moving to SLEEP (0 = off) |
| stateCode | output | 3 | Current state code |
| regAccessOk | output | 1 | Host register access permitted |
| chanRunOk | output | 1 | Channels may be started and run |
| evtValid | output | 1 | One-cycle state-change event request |
| evtState | output | 3 | New state code carried by the event request |
| wrDropped | output | 1 | A host write was discarded because the controller was in reset |

## Verification
The bench targets the exact timeout edge. It idles for one cycle less than the limit, injects activity, and then idles for the full limit. A counter that is off by one, or that keeps counting through activity, shows up as an IDLE entry one cycle early or late. It also sets a suspend request, link activity and timer expiry all in one cycle, where a wrong priority ends in ACTIVE or SLEEP instead of SUSPEND. Further cases are a zero limit and a limit lowered under a running count, where a timer using equality stalls forever. Writes in reset must leave a one-cycle drop flag and no state change. Link activity in SUSPEND must not wake the controller. A constrained random phase compares every output in every cycle against a bench model, so a misplaced or repeated event request is caught.

// File: rtl/lps_pkg.sv
package lps_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_RESET   = 3'd0,
    PS_READY   = 3'd1,
    PS_ACTIVE  = 3'd2,
    PS_IDLE    = 3'd3,
    PS_SLEEP   = 3'd4,
    PS_SUSPEND = 3'd5
  } pwrState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic               tmrClr;   // restart the idle counter
    logic               evtFire;  // a state change happens at this edge
    logic [STATE_W-1:0] evtCode;  // state being entered
    logic               dropWr;   // host write arrived during reset
  } lpsStrobe_t;

endpackage

// File: rtl/lps_datapath.sv
module lps_datapath
  import lps_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  lpsStrobe_t         strb,
  input  logic               linkActive,
  input  logic [TIMER_W-1:0] limFast,
  input  logic [TIMER_W-1:0] limSlow,
  output logic               expFast,
  output logic               expSlow,
  output logic               evtValid,
  output logic [STATE_W-1:0] evtState,
  output logic               wrDropped
);

  localparam logic [TIMER_W-1:0] CNT_ONE = TIMER_W'(1);
  localparam logic [TIMER_W-1:0] CNT_MAX = '1;

  logic [TIMER_W-1:0] idleCnt;

  // idle cycles already seen in the current state; saturates
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strb.tmrClr) begin
      idleCnt <= '0;
    end else if (idleCnt != CNT_MAX) begin
      idleCnt <= idleCnt + CNT_ONE;
    end
  end

  // this cycle is the limit-th idle one (or later, if the limit was lowered)
  always_comb begin
    expFast = (limFast != '0) && !linkActive && (idleCnt >= (limFast - CNT_ONE));
    expSlow = (limSlow != '0) && !linkActive && (idleCnt >= (limSlow - CNT_ONE));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtValid  <= 1'b0;
      evtState  <= '0;
      wrDropped <= 1'b0;
    end else begin
      evtValid  <= strb.evtFire;
      wrDropped <= strb.dropWr;
      if (strb.evtFire) begin
        evtState <= strb.evtCode;
      end
    end
  end

endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [STATE_W-1:0] reqState,
  input  logic               linkActive,
  input  logic               devReady,
  input  logic               expFast,
  input  logic               expSlow,
  output pwrState_t          curState,
  output lpsStrobe_t         strb
);

  pwrState_t nxtState;
  logic      suspReq;
  logic      wakeReq;
  logic      tmrRun;
  logic      changing;

  always_comb begin
    suspReq = reqValid && (reqState == PS_SUSPEND);
    wakeReq = reqValid && (reqState == PS_ACTIVE);
  end

  always_comb begin
    nxtState = curState;
    unique case (curState)
      PS_RESET:   if (devReady) nxtState = PS_READY;
      PS_READY:   if (wakeReq)  nxtState = PS_ACTIVE;
      PS_ACTIVE: begin
        if (suspReq)      nxtState = PS_SUSPEND;
        else if (expFast) nxtState = PS_IDLE;
      end
      PS_IDLE: begin
        if (suspReq)         nxtState = PS_SUSPEND;
        else if (linkActive) nxtState = PS_ACTIVE;
        else if (expSlow)    nxtState = PS_SLEEP;
      end
      PS_SLEEP: begin
        if (suspReq)         nxtState = PS_SUSPEND;
        else if (linkActive) nxtState = PS_ACTIVE;
      end
      PS_SUSPEND: if (wakeReq) nxtState = PS_ACTIVE;
      default:    nxtState = PS_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= PS_RESET;
    end else begin
      curState <= nxtState;
    end
  end

  always_comb begin
    tmrRun       = (curState == PS_ACTIVE) || (curState == PS_IDLE);
    changing     = (nxtState != curState);
    strb.tmrClr  = changing || linkActive || !tmrRun;
    strb.evtFire = changing;
    strb.evtCode = nxtState;
    strb.dropWr  = (curState == PS_RESET) && reqValid;
  end

endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
  import lps_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [2:0]         reqState,
  input  logic               linkActive,
  input  logic               devReady,
  input  logic [TIMER_W-1:0] idleLimitFast,
  input  logic [TIMER_W-1:0] idleLimitSlow,
  output logic [2:0]         stateCode,
  output logic               regAccessOk,
  output logic               chanRunOk,
  output logic               evtValid,
  output logic [2:0]         evtState,
  output logic               wrDropped
);

  pwrState_t  curState;
  lpsStrobe_t strb;
  logic       expFast;
  logic       expSlow;

  lps_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqState   (reqState),
    .linkActive (linkActive),
    .devReady   (devReady),
    .expFast    (expFast),
    .expSlow    (expSlow),
    .curState   (curState),
    .strb       (strb)
  );

  lps_datapath #(.TIMER_W(TIMER_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .linkActive (linkActive),
    .limFast    (idleLimitFast),
    .limSlow    (idleLimitSlow),
    .expFast    (expFast),
    .expSlow    (expSlow),
    .evtValid   (evtValid),
    .evtState   (evtState),
    .wrDropped  (wrDropped)
  );

  assign stateCode   = curState;
  assign regAccessOk = (curState != PS_RESET);
  assign chanRunOk   = (curState == PS_ACTIVE);

endmodule

// File: rtl/link_pwr_ctrl_chk.sv
module link_pwr_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [2:0] reqState,
  input logic       linkActive,
  input logic       devReady,
  input logic [2:0] stateCode,
  input logic       regAccessOk,
  input logic       chanRunOk,
  input logic       evtValid,
  input logic [2:0] evtState,
  input logic       wrDropped
);

  p_reset_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd0) |-> !regAccessOk);

  p_chan_only_active_r5: assert property (@(posedge clk) disable iff (!rstN)
    chanRunOk |-> (stateCode == 3'd2));

  p_reset_exit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd0) |=> (stateCode == 3'd0 || stateCode == 3'd1));

  p_drop_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd0 && reqValid) |=> wrDropped);

  p_ready_exit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd1) |=> (stateCode == 3'd1 || stateCode == 3'd2));

  p_sleep_wake_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd4 && linkActive && !(reqValid && reqState == 3'd5))
      |=> (stateCode == 3'd2));

  p_suspend_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((stateCode == 3'd2 || stateCode == 3'd3 || stateCode == 3'd4) &&
     reqValid && reqState == 3'd5) |=> (stateCode == 3'd5));

  p_suspend_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd5 && !(reqValid && reqState == 3'd2)) |=> (stateCode == 3'd5));

  p_evt_code_r12: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtState == stateCode));

  p_evt_on_change_r12: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode != $past(stateCode)) |-> evtValid);

  p_evt_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |=> !evtValid || (stateCode != $past(stateCode)));

endmodule

bind link_pwr_ctrl link_pwr_ctrl_chk u_chk (.*);

// File: tb/link_pwr_ctrl_bench.sv
module link_pwr_ctrl_bench;

  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid;
  logic [2:0]    reqState;
  logic          linkActive;
  logic          devReady;
  logic [TW-1:0] idleLimitFast;
  logic [TW-1:0] idleLimitSlow;
  logic [2:0]    stateCode;
  logic          regAccessOk;
  logic          chanRunOk;
  logic          evtValid;
  logic [2:0]    evtState;
  logic          wrDropped;

  int nRun  = 0;
  int nFail = 0;

  // bench model of the expected outputs
  int   mState = 0;
  int   mCnt   = 0;
  bit   mEvt   = 1'b0;
  int   mEvtCode = 0;
  bit   mDrop  = 1'b0;

  always #5 clk = ~clk;

  link_pwr_ctrl #(.TIMER_W(TW)) u_link_pwr_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqState(reqState),
    .linkActive(linkActive), .devReady(devReady),
    .idleLimitFast(idleLimitFast), .idleLimitSlow(idleLimitSlow),
    .stateCode(stateCode), .regAccessOk(regAccessOk), .chanRunOk(chanRunOk),
    .evtValid(evtValid), .evtState(evtState), .wrDropped(wrDropped)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit expired(input int lim, input int cnt, input bit la);
    return (lim != 0) && !la && (cnt >= lim - 1);
  endfunction

  function automatic int modelNext(input int st, input bit rv, input int rs,
                                   input bit la, input bit dr, input int cnt);
    bit susp = rv && (rs == 5);
    bit wake = rv && (rs == 2);
    case (st)
      0: return dr ? 1 : 0;
      1: return wake ? 2 : 1;
      2: if (susp) return 5;
         else if (expired(int'(idleLimitFast), cnt, la)) return 3;
         else return 2;
      3: if (susp) return 5;
         else if (la) return 2;
         else if (expired(int'(idleLimitSlow), cnt, la)) return 4;
         else return 3;
      4: if (susp) return 5;
         else if (la) return 2;
         else return 4;
      default: return wake ? 2 : 5;
    endcase
  endfunction

  task automatic compareAll(input string tag);
    check(int'(stateCode) == mState, tag, "stateCode", int'(stateCode), mState);
    check(regAccessOk == (mState != 0), {tag, "/R5"}, "regAccessOk",
          int'(regAccessOk), int'(mState != 0));
    check(chanRunOk == (mState == 2), {tag, "/R5"}, "chanRunOk",
          int'(chanRunOk), int'(mState == 2));
    check(evtValid == mEvt, {tag, "/R12"}, "evtValid", int'(evtValid), int'(mEvt));
    if (mEvt) check(int'(evtState) == mEvtCode, {tag, "/R12"}, "evtState",
                    int'(evtState), mEvtCode);
    check(wrDropped == mDrop, {tag, "/R3"}, "wrDropped", int'(wrDropped), int'(mDrop));
  endtask

  // drive one cycle of inputs after a falling edge, compare at the next one
  task automatic step(input bit rv, input int rs, input bit la, input bit dr,
                      input string tag);
    int nState;
    int nCnt;
    bit chg;
    reqValid   = rv;
    reqState   = 3'(rs);
    linkActive = la;
    devReady   = dr;
    nState = modelNext(mState, rv, rs, la, dr, mCnt);
    chg    = (nState != mState);
    nCnt   = (chg || la || !(mState == 2 || mState == 3)) ? 0 : mCnt + 1;
    mDrop  = (mState == 0) && rv;
    @(negedge clk);
    mEvt     = chg;
    mEvtCode = nState;
    mState   = nState;
    mCnt     = nCnt;
    compareAll(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 1'b1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; reqValid = 1'b0; reqState = 3'd0; linkActive = 1'b0;
    devReady = 1'b0; idleLimitFast = TW'(4); idleLimitSlow = TW'(3);
    repeat (3) @(negedge clk);
    compareAll("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 after reset");

    // R3: writes during reset are dropped
    step(1'b1, 2, 1'b0, 1'b0, "R3 drop write");
    step(1'b0, 0, 1'b0, 1'b0, "R3 flag clears");
    step(1'b0, 0, 1'b1, 1'b0, "R2 hold without ready");
    // R2: ready leaves reset
    step(1'b0, 0, 1'b0, 1'b1, "R2 to ready");
    check(stateCode == 3'd1, "R2", "ready code", int'(stateCode), 1);
    // R4: only request 2 leaves READY
    step(1'b1, 5, 1'b0, 1'b1, "R4 ignore code 5");
    step(1'b1, 3, 1'b1, 1'b1, "R4 ignore code 3");
    step(1'b1, 2, 1'b0, 1'b1, "R4 to active");
    check(chanRunOk == 1'b1, "R5", "chanRunOk in active", int'(chanRunOk), 1);
    // R6: idle count restarts on activity
    idle(3, "R6 below limit");
    step(1'b0, 0, 1'b1, 1'b1, "R6 activity");
    idle(3, "R6 recount");
    check(stateCode == 3'd2, "R6", "still active", int'(stateCode), 2);
    idle(1, "R6 expire");
    check(stateCode == 3'd3, "R6", "idle entered", int'(stateCode), 3);
    // R7: activity in IDLE returns to ACTIVE
    step(1'b0, 0, 1'b1, 1'b1, "R7 wake");
    check(stateCode == 3'd2, "R7", "back to active", int'(stateCode), 2);
    // R8: second timeout into SLEEP
    idle(4, "R7 recount");
    idle(2, "R8 below limit");
    check(stateCode == 3'd3, "R8", "still idle", int'(stateCode), 3);
    idle(1, "R8 expire");
    check(stateCode == 3'd4, "R8", "sleep entered", int'(stateCode), 4);
    idle(10, "R9 no timer in sleep");
    // R9: activity wakes SLEEP
    step(1'b0, 0, 1'b1, 1'b1, "R9 wake");
    check(stateCode == 3'd2, "R9", "active after sleep", int'(stateCode), 2);
    // R10: suspend beats expiry in ACTIVE
    idle(3, "R10 prepare");
    step(1'b1, 5, 1'b0, 1'b1, "R10 beats expiry");
    check(stateCode == 3'd5, "R10", "suspend", int'(stateCode), 5);
    // R11: SUSPEND ignores activity and other codes
    step(1'b0, 0, 1'b1, 1'b1, "R11 ignore activity");
    step(1'b1, 3, 1'b1, 1'b1, "R11 ignore code 3");
    step(1'b1, 0, 1'b0, 1'b1, "R11 ignore code 0");
    step(1'b1, 2, 1'b0, 1'b1, "R11 resume");
    // R10: suspend beats activity in IDLE
    idle(4, "R10 to idle");
    step(1'b1, 5, 1'b1, 1'b1, "R10 beats activity");
    check(stateCode == 3'd5, "R10", "suspend from idle", int'(stateCode), 5);
    step(1'b1, 2, 1'b0, 1'b1, "R11 resume again");
    // R6: zero limit disables, lowered limit expires at once
    idleLimitFast = TW'(0);
    idle(20, "R6 limit zero");
    check(stateCode == 3'd2, "R6", "no timeout at zero", int'(stateCode), 2);
    idleLimitFast = TW'(3);
    idle(1, "R6 lowered limit");
    check(stateCode == 3'd3, "R6", "expire after lowering", int'(stateCode), 3);
    // R8: zero slow limit
    idleLimitSlow = TW'(0);
    idle(15, "R8 limit zero");
    check(stateCode == 3'd3, "R8", "no sleep at zero", int'(stateCode), 3);

    // constrained random phase
    for (int blk = 0; blk < 20; blk++) begin
      idleLimitFast = TW'($urandom_range(0, 6));
      idleLimitSlow = TW'($urandom_range(0, 6));
      for (int i = 0; i < 150; i++) begin
        step(($urandom_range(0, 7) == 0), int'($urandom_range(0, 7)),
             ($urandom_range(0, 4) == 0), 1'b1, "RND");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule